// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Hysteresis Predictor

This unit sits beside the fetch stage and guesses, for each fetch address, whether a branch lives there, whether it will be taken, and where it goes. It keeps a small direct-mapped table. Each entry holds a valid bit, an address tag, a target address and a two-bit history. One history bit is the direction guess for the next occurrence. The other records whether the previous guess turned out right. A lookup is purely combinational on the current table contents. It reports a hit, the taken guess, the stored target and the address to fetch next.

When a branch resolves, the execute stage presents its address, its real target and its real direction on the update port. If the entry selected by that address already holds the branch, only its history moves. Otherwise the entry is overwritten with the new branch, and the history is seeded from the direction just seen. The history is not a saturating counter. A single wrong guess only clears the "last guess right" bit. The direction flips only when a second consecutive wrong guess arrives.

Updates take effect at the clock edge. A lookup made in the same cycle as an update therefore sees the table as it was before that update.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid: every lookup misses, reports not taken, a target of zero and a next address of the lookup address plus 4.
- R2: The entry is chosen by address bits [3:2]. A lookup hits only when that entry is valid and its stored tag equals address bits [31:4].
- R3: On a hit whose direction bit is 1, the lookup reports taken, outputs the stored target, and gives that target as the next address.
- R4: On a miss, or on a hit whose direction bit is 0, the lookup reports not taken and gives the lookup address plus 4 as the next address. The target output is the stored target on a hit and zero on a miss.
- R5: An update that hits with a correct guess (direction bit equal to the outcome) keeps the direction bit and sets the last-correct bit to 1.
- R6: An update that hits with a wrong guess while the last-correct bit is 1 keeps the direction bit and clears the last-correct bit.
- R7: An update that hits with a wrong guess while the last-correct bit is 0 inverts the direction bit and sets the last-correct bit to 1.
- R8: An update that misses writes the entry with the new tag and target, sets it valid, and seeds the history to direction 1 / last-correct 1 when taken, or direction 0 / last-correct 1 when not taken.
- R9: An update that hits leaves the stored tag and target unchanged, even when the presented target differs.
- R10: A missing update to an index already holding a different branch evicts that branch, so lookups of the evicted address then miss.
- R11: A lookup in the same cycle as an update to the same entry reports the state from before the update. The new state is visible from the next cycle.
- R12: While the update valid input is low, the update address, target and outcome inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lkPc | input | 32 | Fetch address to look up |
| lkHit | output | 1 | Lookup found a matching valid entry |
| lkTaken | output | 1 | Lookup predicts taken |
| lkTarget | output | 32 | Stored target on a hit, zero otherwise |
| lkNextPc | output | 32 | Predicted next fetch address |
| updValid | input | 1 | Resolved branch present on the update port this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTarget | input | 32 | Actual target of the resolved branch |
| updTaken | input | 1 | Actual direction of the resolved branch |

## Verification
The hardest condition to reach from the ports is a history with the last-correct bit cleared. That bit is never output. It shows only in whether the next wrong outcome flips the taken guess. The stimulus drives one branch through a fixed ladder of outcomes: seed taken, then not taken twice, then taken, not taken and taken. After each step it looks up the branch, so every transition of R5 to R7 shows up as a taken or not-taken prediction at the right step. Conflicting tags at one index are forced by drawing random addresses from only three tag values, which makes eviction and re-seeding frequent. Same-cycle lookups are checked both before and after the edge.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // two-bit hysteresis history for one entry
  typedef struct packed {
    logic predN;   // direction guess for next occurrence, 1 = taken
    logic lastOk;  // 1 = previous guess was right
  } histT;

  // strobes from control to datapath for one update cycle
  typedef struct packed {
    logic histWr;   // rewrite history of the hitting entry
    logic lineWr;   // replace the whole entry
    histT newHist;  // history value to write
  } ctrlT;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic updValid,
  input  logic updTaken,
  input  logic updHit,
  input  histT curHist,
  output ctrlT ctrl
);
  logic guessRight;

  assign guessRight = (curHist.predN == updTaken);

  always_comb begin
    ctrl = '0;
    if (updValid) begin
      if (updHit) begin
        ctrl.histWr = 1'b1;
        if (guessRight) begin
          ctrl.newHist = '{predN: curHist.predN, lastOk: 1'b1};
        end else if (curHist.lastOk) begin
          ctrl.newHist = '{predN: curHist.predN, lastOk: 1'b0};
        end else begin
          ctrl.newHist = '{predN: ~curHist.predN, lastOk: 1'b1};
        end
      end else begin
        ctrl.lineWr  = 1'b1;
        ctrl.newHist = '{predN: updTaken, lastOk: 1'b1};
      end
    end
  end
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkPc,
  output logic              lkHit,
  output logic              lkTaken,
  output logic [ADDR_W-1:0] lkTarget,
  output logic [ADDR_W-1:0] lkNextPc,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              updHit,
  output histT              curHist,
  input  ctrlT              ctrl
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_LO = IDX_W + 2;
  localparam int TAG_W  = ADDR_W - TAG_LO;

  logic [LINES-1:0]  lineVal;
  logic [TAG_W-1:0]  lineTag [LINES];
  logic [ADDR_W-1:0] lineTgt [LINES];
  histT              lineHist[LINES];

  logic [IDX_W-1:0] lkIdx, upIdx;
  logic [TAG_W-1:0] lkTag, upTag;
  logic [3:0]       unusedBits;

  assign lkIdx = lkPc[TAG_LO-1:2];
  assign lkTag = lkPc[ADDR_W-1:TAG_LO];
  assign upIdx = updPc[TAG_LO-1:2];
  assign upTag = updPc[ADDR_W-1:TAG_LO];
  assign unusedBits = {lkPc[1:0], updPc[1:0]};

  // lookup path: reads registered state only
  assign lkHit    = lineVal[lkIdx] && (lineTag[lkIdx] == lkTag);
  assign lkTaken  = lkHit && lineHist[lkIdx].predN;
  assign lkTarget = lkHit ? lineTgt[lkIdx] : '0;
  assign lkNextPc = lkTaken ? lkTarget : lkPc + ADDR_W'(4);

  // update path read side
  assign updHit  = lineVal[upIdx] && (lineTag[upIdx] == upTag);
  assign curHist = lineHist[upIdx];

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic sel;
    assign sel = (upIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineVal[g]  <= 1'b0;
        lineTag[g]  <= '0;
        lineTgt[g]  <= '0;
        lineHist[g] <= '0;
      end else if (sel && ctrl.lineWr) begin
        lineVal[g]  <= 1'b1;
        lineTag[g]  <= upTag;
        lineTgt[g]  <= updTarget;
        lineHist[g] <= ctrl.newHist;
      end else if (sel && ctrl.histWr) begin
        lineHist[g] <= ctrl.newHist;
      end
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkPc,
  output logic              lkHit,
  output logic              lkTaken,
  output logic [ADDR_W-1:0] lkTarget,
  output logic [ADDR_W-1:0] lkNextPc,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updTaken
);
  ctrlT ctrl;
  logic updHit;
  histT curHist;

  btb_ctrl uCtrl (
    .updValid(updValid),
    .updTaken(updTaken),
    .updHit  (updHit),
    .curHist (curHist),
    .ctrl    (ctrl)
  );

  btb_store #(.ADDR_W(ADDR_W), .LINES(LINES)) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .lkPc     (lkPc),
    .lkHit    (lkHit),
    .lkTaken  (lkTaken),
    .lkTarget (lkTarget),
    .lkNextPc (lkNextPc),
    .updPc    (updPc),
    .updTarget(updTarget),
    .updHit   (updHit),
    .curHist  (curHist),
    .ctrl     (ctrl)
  );
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] lkPc,
  input logic              lkHit,
  input logic              lkTaken,
  input logic [ADDR_W-1:0] lkTarget,
  input logic [ADDR_W-1:0] lkNextPc,
  input logic              updValid,
  input logic [ADDR_W-1:0] updPc
);
  // R3
  taken_follows_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && lkTaken) |-> (lkNextPc == lkTarget));

  // R4
  miss_falls_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (!lkTaken && lkTarget == '0 && lkNextPc == lkPc + ADDR_W'(4)));

  // R12
  idle_update_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!updValid && lkPc == $past(lkPc)) |=> ($past(lkPc) != lkPc) ||
      ($stable(lkHit) && $stable(lkTaken) && $stable(lkTarget)));

  // R8
  update_installs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updPc == lkPc) |=> ($past(lkPc) != lkPc) || lkHit);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    $past(!rstN) && !updValid |-> !lkHit || !$past(!rstN));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .lkPc    (lkPc),
  .lkHit   (lkHit),
  .lkTaken (lkTaken),
  .lkTarget(lkTarget),
  .lkNextPc(lkNextPc),
  .updValid(updValid),
  .updPc   (updPc)
);

// File: tb/btb_predictor_test.sv
`timescale 1ns/1ps
module btb_predictor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkPc = '0;
  logic        lkHit, lkTaken;
  logic [31:0] lkTarget, lkNextPc;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic        updTaken = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model
  bit        mVal [4];
  bit [27:0] mTag [4];
  bit [31:0] mTgt [4];
  bit        mN   [4];
  bit        mL   [4];

  always #2.5 clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkHit(lkHit), .lkTaken(lkTaken),
    .lkTarget(lkTarget), .lkNextPc(lkNextPc), .updValid(updValid),
    .updPc(updPc), .updTarget(updTarget), .updTaken(updTaken)
  );

  function automatic bit [31:0] mkPc(int tagSel, int idx);
    return {28'h0ABC000 + 28'(tagSel), 2'(idx), 2'b00};
  endfunction

  function automatic bit [97:0] expLookup(bit [31:0] pc);
    bit [1:0]  i;
    bit        h, t;
    bit [31:0] tg, nx;
    i  = pc[3:2];
    h  = mVal[i] && (mTag[i] == pc[31:4]);
    t  = h && mN[i];
    tg = h ? mTgt[i] : 32'h0;
    nx = t ? tg : pc + 32'd4;
    return {h, t, tg, nx};
  endfunction

  function automatic void modelUpdate(bit [31:0] pc, bit [31:0] tgt, bit tk);
    bit [1:0] i;
    i = pc[3:2];
    if (mVal[i] && mTag[i] == pc[31:4]) begin
      if (mN[i] == tk) mL[i] = 1;
      else if (mL[i]) mL[i] = 0;
      else begin mN[i] = ~mN[i]; mL[i] = 1; end
    end else begin
      mVal[i] = 1; mTag[i] = pc[31:4]; mTgt[i] = tgt; mN[i] = tk; mL[i] = 1;
    end
  endfunction

  task automatic checkLookup(string req);
    bit [97:0] e, a;
    e = expLookup(lkPc);
    a = {lkHit, lkTaken, lkTarget, lkNextPc};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s pc=%h got hit=%b tk=%b tgt=%h nx=%h exp hit=%b tk=%b tgt=%h nx=%h",
               req, lkPc, a[97], a[96], a[95:64], a[63:32], e[97], e[96], e[95:64], e[63:32]);
    end
  endtask

  // one cycle: drive at negedge, check lookup against pre-edge model, apply edge
  task automatic step(string req, bit [31:0] pc, bit uv, bit [31:0] upc,
                      bit [31:0] utgt, bit utk);
    @(negedge clk);
    lkPc = pc; updValid = uv; updPc = upc; updTarget = utgt; updTaken = utk;
    #1 checkLookup(req);
    @(posedge clk);
    if (uv) modelUpdate(upc, utgt, utk);
  endtask

  task automatic look(string req, bit [31:0] pc);
    step(req, pc, 1'b0, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic upd(bit [31:0] pc, bit [31:0] tgt, bit tk);
    step("R2", pc, 1'b1, pc, tgt, tk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] a, b;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4; i++) begin mVal[i] = 0; mN[i] = 0; mL[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: all entries empty after reset
    for (int i = 0; i < 4; i++) look("R1", mkPc(0, i));

    // R8: seed taken, R3 lookup predicts taken with target
    a = mkPc(0, 1);
    upd(a, 32'h0000_4000, 1'b1);
    look("R3", a);
    // R6: one wrong guess keeps direction
    upd(a, 32'h0000_4000, 1'b0);
    look("R6", a);
    // R7: second wrong guess flips direction
    upd(a, 32'h0000_4000, 1'b0);
    look("R7", a);
    // wrong again (last-correct was set) -> keep not taken
    upd(a, 32'h0000_4000, 1'b1);
    look("R6", a);
    // R5: correct guess restores last-correct
    upd(a, 32'h0000_4000, 1'b0);
    look("R5", a);
    // wrong once more: must not flip because R5 restored last-correct
    upd(a, 32'h0000_4000, 1'b1);
    look("R5", a);
    upd(a, 32'h0000_4000, 1'b1);
    look("R7", a);

    // R8: seed not taken -> R4 not taken with stored target
    b = mkPc(1, 2);
    upd(b, 32'h0000_8800, 1'b0);
    look("R4", b);
    // R2: same index, different tag misses
    look("R2", mkPc(2, 2));
    // R9: hit update with different target keeps old target
    upd(b, 32'h0000_9900, 1'b1);
    upd(b, 32'h0000_9900, 1'b1);
    look("R9", b);
    // R10: conflicting tag evicts
    upd(mkPc(2, 2), 32'h0000_AA00, 1'b1);
    look("R10", b);
    look("R10", mkPc(2, 2));
    // R12: idle update inputs change nothing
    step("R12", a, 1'b0, a, 32'h1234_5670, 1'b0);
    look("R12", a);
    // R11: lookup and update same entry same cycle; step checks pre-edge state
    step("R11", mkPc(0, 3), 1'b1, mkPc(0, 3), 32'h0000_C000, 1'b1);
    look("R11", mkPc(0, 3));
    step("R11", a, 1'b1, a, 32'h0, 1'b0);
    look("R11", a);

    // random mix over few tags to force conflicts
    for (int n = 0; n < 400; n++) begin
      bit [31:0] lp, up;
      lp = mkPc(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)));
      up = mkPc(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)));
      step("R2", lp, ($urandom_range(0, 9) < 6), up,
           {$urandom_range(0, 32'h0FFF_FFFF), 2'b00} & 32'h3FFF_FFFC,
           1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule